// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers and the control registers of a small 32-bit processor core. Sixteen architectural registers are visible to instructions. The upper eight are one physical set that every mode shares. The lower eight have two physical copies. Which copy an ordinary access reaches depends on the processor mode bit and on a bank-select bit, and both of these bits live in the status register. The core reads two operands combinationally and writes one result per clock.

Privileged code sometimes has to reach the low-register copy that is not currently mapped, for example to save the other context. A separate alternate-bank port serves that case, and it always addresses the unmapped copy. The control registers sit behind one selector port. Some of them may be used in any mode; the rest exist only for privileged code. If user code tries to use a privileged resource, the access is suppressed and a flag is raised for one cycle. The current bank's R0 is driven on a dedicated output for indexed address generation.

The ports are plain, single-cycle register-file ports. They have no valid/ready handshake and never stall. A write enable commits on the next rising clock edge, and reads are purely combinational.

Top module: `bnk_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every general register and every control register to zero. The exception is the status register, which resets to 0x6000_0000: the mode bit (bit 30) and the bank bit (bit 29) are both set. After reset, cur_bank reads 1 and illegal reads 0.
- R2: General reads and writes of indices 0–7 use the low-register copy numbered (mode bit AND bank bit). In user mode (mode bit 0) this is copy 0, whatever the bank bit holds.
- R3: Indices 8–15 reach a single physical set. It returns the same contents in every mode and for every bank setting.
- R4: Switching the mode bit or the bank bit never alters stored contents. Returning to a copy shows exactly the values last written to it.
- R5: In privileged mode, alt_wr_en writes and alt_rd_en reads entry alt_*_idx (0–7) of the copy that is not currently mapped.
- R6: In user mode, an alternate-bank access is suppressed: a write changes nothing and a read returns zero. illegal is 1 in the cycle after the attempt and 0 again one cycle later if no new attempt follows. In privileged mode, illegal never rises.
- R7: Control selector codes: 0 status, 1 global base, 2 multiply-high, 3 multiply-low, 4 procedure return, 5 program counter. These codes are readable and writable in every mode.
- R8: Selector codes 8 (saved status), 9 (vector base), 10 (saved program counter), 11 (saved general R15) and 12 (debug base) work only in privileged mode. A user-mode access to any of them reads zero, writes nothing, and raises illegal in the next cycle.
- R9: index_r0 always equals R0 of the currently mapped copy.
- R10: No bypass is applied. In the cycle of a write, a read of the same register returns the old value. The new value is readable from the next cycle on.
- R11: A write to the status register changes the mapping from the next cycle on. A general write in the same cycle still lands in the copy that was mapped before the change.
- R12: The two read ports select independently. Selector codes 6, 7, 13, 14 and 15 read zero, ignore writes and do not raise illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| alt_rd_en | input | 1 | Alternate-bank read request |
| alt_rd_idx | input | 3 | Alternate-bank read index |
| alt_rd_data | output | 32 | Alternate-bank read data (zero when suppressed) |
| alt_wr_en | input | 1 | Alternate-bank write enable |
| alt_wr_idx | input | 3 | Alternate-bank write index |
| alt_wr_data | input | 32 | Alternate-bank write data |
| cr_sel | input | 4 | Control register selector code |
| cr_rd_en | input | 1 | Control register read request |
| cr_rd_data | output | 32 | Control register read data |
| cr_wr_en | input | 1 | Control register write enable |
| cr_wr_data | input | 32 | Control register write data |
| index_r0 | output | 32 | R0 of the mapped copy |
| priv_mode | output | 1 | Current mode bit |
| cur_bank | output | 1 | Currently mapped low copy |
| illegal | output | 1 | One-cycle flag for a suppressed access |

## Verification
The main check writes values through the general port, flips the status bits through all four mode/bank combinations, and then reads back low and high indices. A value that shows up in the wrong copy, or a high register that differs between modes, separates the mapping from plain storage. Alternate-port reads and writes made under both privileged bank settings confirm that the port always reaches the opposite copy and never the mapped one. The directed cases are user-mode attempts, a read that coincides with a write, and a status write that coincides with a general write. Together they separate suppression from mere misrouting and show in which cycle a mapping change takes effect.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;

  typedef enum logic [3:0] {
    CR_STATUS = 4'd0,
    CR_GBASE  = 4'd1,
    CR_MACHI  = 4'd2,
    CR_MACLO  = 4'd3,
    CR_RET    = 4'd4,
    CR_PCNT   = 4'd5,
    CR_SVSTAT = 4'd8,
    CR_VBASE  = 4'd9,
    CR_SVPC   = 4'd10,
    CR_SVR15  = 4'd11,
    CR_DBASE  = 4'd12
  } cr_code_e;

  function automatic logic cr_exists(input logic [3:0] sel);
    return (sel <= 4'd5) || (sel >= 4'd8 && sel <= 4'd12);
  endfunction

  function automatic logic cr_priv_only(input logic [3:0] sel);
    return sel[3] && cr_exists(sel);
  endfunction
endpackage

// File: rtl/bnk_access_guard.sv
module bnk_access_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       md,
  input  logic       rb,
  input  logic       alt_rd_en,
  input  logic       alt_wr_en,
  input  logic       cr_rd_en,
  input  logic       cr_wr_en,
  input  logic [3:0] cr_sel,
  output logic       cur_bank,
  output logic       alt_ok,
  output logic       cr_ok,
  output logic       illegal_q
);
  import bnk_pkg::*;

  logic bad_alt, bad_cr;

  always_comb begin
    cur_bank = md & rb;
    alt_ok   = md;
    cr_ok    = md | ~cr_priv_only(cr_sel);
    bad_alt  = ~md & (alt_rd_en | alt_wr_en);
    bad_cr   = (cr_rd_en | cr_wr_en) & ~cr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= bad_alt | bad_cr;
  end
endmodule

// File: rtl/bnk_gpr_array.sv
module bnk_gpr_array #(
  parameter int DW     = 32,
  parameter int NUM_LO = 8,
  parameter int NUM_HI = 8,
  localparam int IDX_W = $clog2(NUM_LO + NUM_HI),
  localparam int LO_W  = $clog2(NUM_LO),
  localparam int HI_W  = $clog2(NUM_HI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_bank,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             alt_rd_ok,
  input  logic [LO_W-1:0]  alt_rd_idx,
  output logic [DW-1:0]    alt_rd_data,
  input  logic             alt_wr_ok,
  input  logic [LO_W-1:0]  alt_wr_idx,
  input  logic [DW-1:0]    alt_wr_data,
  output logic [DW-1:0]    index_r0
);
  logic [DW-1:0] lo_v [2][NUM_LO];
  logic [DW-1:0] hi_v [NUM_HI];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NUM_LO; i++) begin : g_lo
      logic [DW-1:0] q;
      logic gen_hit, alt_hit;
      assign gen_hit = wr_en && (wr_idx == IDX_W'(i)) && (cur_bank == 1'(b));
      assign alt_hit = alt_wr_ok && (alt_wr_idx == LO_W'(i)) && (cur_bank != 1'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (gen_hit) q <= wr_data;
        else if (alt_hit) q <= alt_wr_data;
      end
      assign lo_v[b][i] = q;
    end
  end

  for (genvar h = 0; h < NUM_HI; h++) begin : g_hi
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(NUM_LO + h))) q <= wr_data;
    end
    assign hi_v[h] = q;
  end

  function automatic logic [DW-1:0] pick(input logic [IDX_W-1:0] idx, input logic bank);
    logic [IDX_W-1:0] off;
    off = idx - IDX_W'(NUM_LO);
    if (idx < IDX_W'(NUM_LO)) return lo_v[bank][idx[LO_W-1:0]];
    else                      return hi_v[off[HI_W-1:0]];
  endfunction

  always_comb begin
    rd_a_data   = pick(rd_a_idx, cur_bank);
    rd_b_data   = pick(rd_b_idx, cur_bank);
    index_r0    = lo_v[cur_bank][0];
    alt_rd_data = alt_rd_ok ? lo_v[~cur_bank][alt_rd_idx] : '0;
  end
endmodule

// File: rtl/bnk_ctrl_regs.sv
module bnk_ctrl_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cr_sel,
  input  logic          cr_ok,
  input  logic          cr_rd_en,
  output logic [DW-1:0] cr_rd_data,
  input  logic          cr_wr_en,
  input  logic [DW-1:0] cr_wr_data,
  output logic          md,
  output logic          rb
);
  import bnk_pkg::*;

  localparam logic [DW-1:0] SR_RST = (DW'(1) << SR_MD_BIT) | (DW'(1) << SR_RB_BIT);

  logic [DW-1:0] cr_v [16];

  for (genvar c = 0; c < 16; c++) begin : g_cr
    if (cr_exists(4'(c))) begin : g_real
      localparam logic [DW-1:0] RST = (c == 0) ? SR_RST : '0;
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else if (cr_wr_en && cr_ok && (cr_sel == 4'(c))) q <= cr_wr_data;
      end
      assign cr_v[c] = q;
    end else begin : g_hole
      assign cr_v[c] = '0;
    end
  end

  always_comb begin
    cr_rd_data = (cr_rd_en && cr_ok) ? cr_v[cr_sel] : '0;
    md         = cr_v[CR_STATUS][SR_MD_BIT];
    rb         = cr_v[CR_STATUS][SR_RB_BIT];
  end
endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile #(
  parameter int DW     = 32,
  parameter int NUM_LO = 8,
  parameter int NUM_HI = 8,
  localparam int IDX_W = $clog2(NUM_LO + NUM_HI),
  localparam int LO_W  = $clog2(NUM_LO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             alt_rd_en,
  input  logic [LO_W-1:0]  alt_rd_idx,
  output logic [DW-1:0]    alt_rd_data,
  input  logic             alt_wr_en,
  input  logic [LO_W-1:0]  alt_wr_idx,
  input  logic [DW-1:0]    alt_wr_data,
  input  logic [3:0]       cr_sel,
  input  logic             cr_rd_en,
  output logic [DW-1:0]    cr_rd_data,
  input  logic             cr_wr_en,
  input  logic [DW-1:0]    cr_wr_data,
  output logic [DW-1:0]    index_r0,
  output logic             priv_mode,
  output logic             cur_bank,
  output logic             illegal
);
  logic md, rb, alt_ok, cr_ok;

  bnk_access_guard u_guard (
    .clk(clk), .rst_n(rst_n), .md(md), .rb(rb),
    .alt_rd_en(alt_rd_en), .alt_wr_en(alt_wr_en),
    .cr_rd_en(cr_rd_en), .cr_wr_en(cr_wr_en), .cr_sel(cr_sel),
    .cur_bank(cur_bank), .alt_ok(alt_ok), .cr_ok(cr_ok), .illegal_q(illegal)
  );

  bnk_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cr_sel(cr_sel), .cr_ok(cr_ok),
    .cr_rd_en(cr_rd_en), .cr_rd_data(cr_rd_data),
    .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .md(md), .rb(rb)
  );

  bnk_gpr_array #(.DW(DW), .NUM_LO(NUM_LO), .NUM_HI(NUM_HI)) u_gpr (
    .clk(clk), .rst_n(rst_n), .cur_bank(cur_bank),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_rd_ok(alt_rd_en & alt_ok), .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data),
    .alt_wr_ok(alt_wr_en & alt_ok), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
    .index_r0(index_r0)
  );

  assign priv_mode = md;
endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk #(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             priv_mode,
  input logic             cur_bank,
  input logic             illegal,
  input logic             alt_rd_en,
  input logic             alt_wr_en,
  input logic             cr_rd_en,
  input logic             cr_wr_en,
  input logic [3:0]       cr_sel,
  input logic             sr_md_next,
  input logic             sr_rb_next,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic [IDX_W-1:0] rd_a_idx,
  input logic [DW-1:0]    rd_a_data,
  input logic [DW-1:0]    index_r0
);
  a_r6_alt_user_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode && (alt_rd_en || alt_wr_en)) |=> illegal);

  a_r8_cr_user_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode && (cr_rd_en || cr_wr_en) && cr_sel >= 4'd8 && cr_sel <= 4'd12) |=> illegal);

  a_r6_quiet_in_priv: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode |=> !illegal);

  a_r9_index_matches_port: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == index_r0));

  a_r10_write_lands_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0 && !(cr_wr_en && cr_sel == 4'd0)) |=> (index_r0 == $past(wr_data)));

  a_r11_bank_follows_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_sel == 4'd0) |=> (cur_bank == ($past(sr_md_next) && $past(sr_rb_next))));
endmodule

bind bnk_regfile bnk_regfile_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .cur_bank(cur_bank),
  .illegal(illegal), .alt_rd_en(alt_rd_en), .alt_wr_en(alt_wr_en),
  .cr_rd_en(cr_rd_en), .cr_wr_en(cr_wr_en), .cr_sel(cr_sel),
  .sr_md_next(cr_wr_data[30]), .sr_rb_next(cr_wr_data[29]),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .index_r0(index_r0)
);

// File: tb/bnk_regfile_tb.sv
module bnk_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, cr_sel = '0;
  logic [31:0] rd_a_data, rd_b_data, alt_rd_data, cr_rd_data, index_r0;
  logic wr_en = 0, alt_rd_en = 0, alt_wr_en = 0, cr_rd_en = 0, cr_wr_en = 0;
  logic [31:0] wr_data = '0, alt_wr_data = '0, cr_wr_data = '0;
  logic [2:0] alt_rd_idx = '0, alt_wr_idx = '0;
  logic priv_mode, cur_bank, illegal;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bnk_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .alt_rd_en(alt_rd_en), .alt_rd_idx(alt_rd_idx),
    .alt_rd_data(alt_rd_data), .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx),
    .alt_wr_data(alt_wr_data), .cr_sel(cr_sel), .cr_rd_en(cr_rd_en),
    .cr_rd_data(cr_rd_data), .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data),
    .index_r0(index_r0), .priv_mode(priv_mode), .cur_bank(cur_bank), .illegal(illegal)
  );

  localparam logic [2:0] K_SR = 3'd0, K_WR = 3'd1, K_RD = 3'd2,
                         K_AW = 3'd3, K_AR = 3'd4, K_IX = 3'd5;
  typedef struct packed { logic [2:0] kind; logic [3:0] idx; logic [31:0] val; } vec_t;
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{K_WR, 4'd0,  32'h1111_0001},   // R2: bank 1 after reset
    '{K_WR, 4'd3,  32'h1111_0003},
    '{K_WR, 4'd8,  32'h8888_0008},
    '{K_SR, 4'd0,  32'h4000_0000},   // privileged, bank 0
    '{K_RD, 4'd0,  32'h0000_0000},   // R2/R4 bank 0 untouched
    '{K_WR, 4'd0,  32'h0000_0A00},
    '{K_WR, 4'd12, 32'hCCCC_000C},
    '{K_AR, 4'd3,  32'h1111_0003},   // R5 alt reaches bank 1
    '{K_AW, 4'd5,  32'h1515_1515},
    '{K_IX, 4'd0,  32'h0000_0A00},   // R9
    '{K_SR, 4'd0,  32'h6000_0000},   // privileged, bank 1
    '{K_RD, 4'd0,  32'h1111_0001},   // R4 retained
    '{K_RD, 4'd5,  32'h1515_1515},
    '{K_RD, 4'd8,  32'h8888_0008},   // R3 shared
    '{K_RD, 4'd12, 32'hCCCC_000C},   // R3 shared
    '{K_AR, 4'd0,  32'h0000_0A00},   // R5 alt reaches bank 0
    '{K_SR, 4'd0,  32'h0000_0000},   // user
    '{K_RD, 4'd0,  32'h0000_0A00},
    '{K_RD, 4'd3,  32'h0000_0000},
    '{K_RD, 4'd12, 32'hCCCC_000C},   // R3 shared in user mode
    '{K_SR, 4'd0,  32'h2000_0000},   // user with bank bit set: R2 still bank 0
    '{K_RD, 4'd0,  32'h0000_0A00},
    '{K_IX, 4'd0,  32'h0000_0A00},
    '{K_SR, 4'd0,  32'h6000_0000}
  };

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic sr_set(input logic [31:0] v);
    cr_sel = 4'd0; cr_wr_data = v; cr_wr_en = 1; cyc(); cr_wr_en = 0;
  endtask

  task automatic gwrite(input logic [3:0] i, input logic [31:0] v);
    wr_idx = i; wr_data = v; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic cr_write(input logic [3:0] s, input logic [31:0] v);
    cr_sel = s; cr_wr_data = v; cr_wr_en = 1; cyc(); cr_wr_en = 0;
  endtask

  task automatic cr_read(input logic [3:0] s, output logic [31:0] v);
    cr_sel = s; cr_rd_en = 1; #1 v = cr_rd_data; cyc(); cr_rd_en = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc();
    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); #1 check("R1 gpr reset", rd_a_data, 32'h0);
    end
    cr_read(4'd0, v);  check("R1 status reset", v, 32'h6000_0000);
    cr_read(4'd1, v);  check("R1 ctrl reset", v, 32'h0);
    check("R1 bank after reset", {31'h0, cur_bank}, 32'h1);
    check("R1 illegal after reset", {31'h0, illegal}, 32'h0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      case (VECS[k].kind)
        K_SR: sr_set(VECS[k].val);
        K_WR: gwrite(VECS[k].idx, VECS[k].val);
        K_RD: begin
          rd_a_idx = VECS[k].idx; rd_b_idx = VECS[k].idx; #1;
          check("R4 read port A", rd_a_data, VECS[k].val);
          check("R4 read port B", rd_b_data, VECS[k].val);
        end
        K_AW: begin
          alt_wr_idx = VECS[k].idx[2:0]; alt_wr_data = VECS[k].val; alt_wr_en = 1;
          cyc(); alt_wr_en = 0;
        end
        K_AR: begin
          alt_rd_idx = VECS[k].idx[2:0]; alt_rd_en = 1; #1;
          check("R5 alt read", alt_rd_data, VECS[k].val);
          alt_rd_en = 0;
        end
        default: begin #1 check("R9 index output", index_r0, VECS[k].val); end
      endcase
    end

    // R6: alternate port in user mode (now bank 1 mapped, privileged)
    sr_set(32'h0000_0000);
    alt_wr_idx = 3'd2; alt_wr_data = 32'hBAD0_0002; alt_wr_en = 1;
    cyc(); alt_wr_en = 0;
    check("R6 flag after alt write", {31'h0, illegal}, 32'h1);
    cyc();
    check("R6 flag drops", {31'h0, illegal}, 32'h0);
    rd_a_idx = 4'd2; #1 check("R6 user bank0 r2 untouched", rd_a_data, 32'h0);
    alt_rd_idx = 3'd5; alt_rd_en = 1; #1 check("R6 user alt read zero", alt_rd_data, 32'h0);
    cyc(); alt_rd_en = 0;
    check("R6 flag after alt read", {31'h0, illegal}, 32'h1);
    sr_set(32'h6000_0000);
    rd_a_idx = 4'd2; #1 check("R6 bank1 r2 untouched", rd_a_data, 32'h0);

    // R7 / R8 control access rules
    cr_write(4'd8, 32'h0000_ABCD);
    cr_write(4'd1, 32'h0000_1234);
    sr_set(32'h0000_0000);
    cr_read(4'd1, v); check("R7 user reads global base", v, 32'h0000_1234);
    check("R7 no flag", {31'h0, illegal}, 32'h0);
    cr_read(4'd8, v); check("R8 user priv read zero", v, 32'h0);
    check("R8 flag on read", {31'h0, illegal}, 32'h1);
    cr_write(4'd8, 32'hFFFF_FFFF);
    check("R8 flag on write", {31'h0, illegal}, 32'h1);
    cr_write(4'd3, 32'h0000_3333);
    cr_read(4'd3, v); check("R7 user writes multiply-low", v, 32'h0000_3333);
    sr_set(32'h6000_0000);
    cr_read(4'd8, v); check("R8 saved status kept", v, 32'h0000_ABCD);

    // R10 no bypass
    rd_a_idx = 4'd9; wr_idx = 4'd9; wr_data = 32'h9999_0009; wr_en = 1; #1;
    check("R10 old value during write", rd_a_data, 32'h0);
    cyc(); wr_en = 0; #1;
    check("R10 new value next cycle", rd_a_data, 32'h9999_0009);

    // R11 status write and general write in same cycle (bank1 -> bank0)
    cr_sel = 4'd0; cr_wr_data = 32'h4000_0000; cr_wr_en = 1;
    wr_idx = 4'd1; wr_data = 32'h7777_0001; wr_en = 1;
    cyc(); cr_wr_en = 0; wr_en = 0;
    check("R11 bank switched", {31'h0, cur_bank}, 32'h0);
    rd_a_idx = 4'd1; #1 check("R11 bank0 r1 untouched", rd_a_data, 32'h0);
    alt_rd_idx = 3'd1; alt_rd_en = 1; #1 check("R11 write landed in old bank", alt_rd_data, 32'h7777_0001);
    alt_rd_en = 0;

    // R12 independent ports and holes in the selector map
    rd_a_idx = 4'd8; rd_b_idx = 4'd12; #1;
    check("R12 port A", rd_a_data, 32'h8888_0008);
    check("R12 port B", rd_b_data, 32'hCCCC_000C);
    sr_set(32'h0000_0000);
    cr_write(4'd6, 32'hDEAD_BEEF);
    check("R12 hole write no flag", {31'h0, illegal}, 32'h0);
    cr_read(4'd6, v); check("R12 hole reads zero", v, 32'h0);
    check("R12 hole read no flag", {31'h0, illegal}, 32'h0);

    finish_run();
  end
endmodule